// File: doc/BRIEF.md
# Frame-Synchronous Double-Buffered Window Configuration

This block keeps the per-window configuration of a multi-window display compositor in two copies. Software writes a staging copy through a simple register port whenever it likes. The live copy, which drives the display pipeline, only changes on a vertical sync strobe. At that strobe, each window's staging fields are copied into its live fields in a single clock edge.

A control register gives every window a hold bit. While a window's hold bit is set, the vsync transfer skips that window. Software can set the bit, rewrite several fields of that window, and clear the bit again. The new values then take effect together at the following vsync, so a half-written setup never reaches the screen.

The same control register carries one channel-enable bit per window. These enable bits take effect immediately. A parameter selects a variant in which a single global hold bit freezes every window at once.

Top module: `vsync_shadow_bank`

## Requirements
- R1: After reset, every staging field, every live field, every hold bit and every channel-enable bit reads as zero.
- R2: Address format is {ctl, live, win[WB-1:0], fld[FB-1:0]}. A write with ctl=0 and live=0 updates the staging field. A read with live=0 returns the staging value. The live copy does not change on any cycle without vsync.
- R3: On a clock edge with vsync high, every window whose hold is not in effect copies all its staging fields into its live fields. Reads with live=1 and the `live_cfg` port then show the new values (window w, field f at bit offset (w*NFIELD+f)*DW).
- R4: A window whose hold is in effect keeps its live fields unchanged across vsync, even when its staging fields differ.
- R5: After a hold bit is cleared, the values held back are copied at the next vsync, and not before it.
- R6: When a staging write and vsync fall in the same cycle, the live copy takes the staging value from before the write, and the staging copy takes the written value.
- R7: A write with ctl=1 loads hold bits from data bits [NWIN-1:0] and channel-enable bits from data bits [16+NWIN-1:16]. The enables appear on `chan_en` on the next cycle and are not affected by vsync. A read with ctl=1 returns the hold and enable bits at those positions.
- R8: With GLOBAL_HOLD=1, only data bit 0 is stored as a hold bit, and it holds every window. The other hold bits read as zero and have no effect.
- R9: Writes with live=1, or with a window or field index out of range, change nothing. Reads of an out-of-range window or field return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address {ctl, live, win, fld} |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Read address {ctl, live, win, fld} |
| rd_data | output | DW | Combinational read data |
| vsync | input | 1 | One-cycle vertical sync strobe |
| live_cfg | output | NWIN*NFIELD*DW | Live copy of all window fields, flattened |
| chan_en | output | NWIN | Per-window channel enables |

## Verification
The bench builds two instances side by side with the default five windows, four fields and 32-bit data. One instance uses per-window hold bits (GLOBAL_HOLD=0) and the other uses the single global hold (GLOBAL_HOLD=1). Both see the same write and vsync traffic. One control write therefore shows a hold on window 1 acting in one instance and being dropped in the other, and a hold on bit 0 freezing only window 0 in one instance and every window in the other.

// File: rtl/vsync_shadow_bank.sv
module vsync_shadow_bank #(
  parameter int NWIN        = 5,
  parameter int NFIELD      = 4,
  parameter int DW          = 32,
  parameter int GLOBAL_HOLD = 0,
  localparam int WB = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int FB = (NFIELD > 1) ? $clog2(NFIELD) : 1,
  localparam int AW = WB + FB + 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [AW-1:0]              wr_addr,
  input  logic [DW-1:0]              wr_data,
  input  logic [AW-1:0]              rd_addr,
  output logic [DW-1:0]              rd_data,
  input  logic                       vsync,
  output logic [NWIN*NFIELD*DW-1:0]  live_cfg,
  output logic [NWIN-1:0]            chan_en
);

  localparam int EN_LSB = 16;

  logic [NWIN-1:0][NFIELD-1:0][DW-1:0] stage_q, live_q;
  logic [NWIN-1:0] hold_q, en_q, hold_eff;

  logic          wr_ctl, wr_live, rd_ctl, rd_live;
  logic [WB-1:0] wr_win, rd_win;
  logic [FB-1:0] wr_fld, rd_fld;
  logic          wr_stage, wr_ctl_hit, rd_inrange;

  assign {wr_ctl, wr_live, wr_win, wr_fld} = wr_addr;
  assign {rd_ctl, rd_live, rd_win, rd_fld} = rd_addr;

  assign wr_stage   = wr_en && !wr_ctl && !wr_live &&
                      int'(wr_win) < NWIN && int'(wr_fld) < NFIELD;
  assign wr_ctl_hit = wr_en && wr_ctl;
  assign rd_inrange = int'(rd_win) < NWIN && int'(rd_fld) < NFIELD;

  assign live_cfg = live_q;
  assign chan_en  = en_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) en_q <= '0;
    else if (wr_ctl_hit) en_q <= wr_data[EN_LSB +: NWIN];

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    if (GLOBAL_HOLD != 0) begin : g_glob
      assign hold_eff[w] = hold_q[0];
    end else begin : g_local
      assign hold_eff[w] = hold_q[w];
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) hold_q[w] <= 1'b0;
      else if (wr_ctl_hit) hold_q[w] <= (GLOBAL_HOLD != 0 && w != 0) ? 1'b0 : wr_data[w];

    for (genvar f = 0; f < NFIELD; f++) begin : g_fld
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          stage_q[w][f] <= '0;
          live_q[w][f]  <= '0;
        end else begin
          if (wr_stage && int'(wr_win) == w && int'(wr_fld) == f)
            stage_q[w][f] <= wr_data;
          if (vsync && !hold_eff[w])
            live_q[w][f] <= stage_q[w][f];
        end
    end

    assert_vsync_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (vsync && !hold_eff[w]) |=> live_q[w] == $past(stage_q[w]))
      else $error("live copy of window %0d missed vsync transfer", w);

    assert_hold_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (vsync && hold_eff[w]) |=> $stable(live_q[w]))
      else $error("held window %0d changed at vsync", w);
  end

  always_comb begin
    rd_data = '0;
    if (rd_ctl) begin
      rd_data[NWIN-1:0]        = hold_q;
      rd_data[EN_LSB +: NWIN]  = en_q;
    end else if (rd_inrange) begin
      rd_data = rd_live ? live_q[rd_win][rd_fld] : stage_q[rd_win][rd_fld];
    end
  end

  assert_live_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync |=> $stable(live_q))
    else $error("live copy changed without vsync");

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (live_q == '0 && stage_q == '0 && hold_q == '0 && en_q == '0))
    else $error("state not cleared by reset");

  assert_ignored_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_ctl && !wr_stage) |=> $stable(stage_q))
    else $error("ignored write altered staging copy");

  if (GLOBAL_HOLD != 0) begin : g_glob_chk
    assert_global_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (vsync && hold_q[0]) |=> $stable(live_q))
      else $error("global hold did not freeze all windows");
  end

endmodule

// File: tb/vsync_shadow_bank_bench.sv
module vsync_shadow_bank_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [6:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [6:0]  rd_addr = '0;
  logic        vsync = 1'b0;
  logic [31:0] rd_a, rd_b;
  logic [639:0] live_a, live_b;
  logic [4:0]  en_a, en_b;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  int          q_src[$];
  int          q_addr[$];
  logic [31:0] q_exp[$];
  string       q_tag[$];

  always #(PERIOD/2) clk = ~clk;

  vsync_shadow_bank #(.GLOBAL_HOLD(0)) u_vsync_shadow_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_a), .vsync(vsync), .live_cfg(live_a), .chan_en(en_a));

  vsync_shadow_bank #(.GLOBAL_HOLD(1)) u_vsync_shadow_bank_g (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_b), .vsync(vsync), .live_cfg(live_b), .chan_en(en_b));

  function automatic logic [6:0] ad(bit c, bit l, int w, int f);
    return {c, l, w[2:0], f[1:0]};
  endfunction

  // src: 0 = rd_data per-window, 1 = rd_data global, 2 = chan_en per-window, 3 = live_cfg slot per-window
  task automatic chk(int src, logic [6:0] a, int slot, logic [31:0] exp, string tag);
    rd_addr = a;
    q_src.push_back(src);
    q_addr.push_back(slot);
    q_exp.push_back(exp);
    q_tag.push_back(tag);
    @(posedge clk); #1;
  endtask

  always @(negedge clk) begin
    if (q_src.size() > 0) begin
      int s, sl;
      logic [31:0] e, g;
      string t;
      s = q_src.pop_front(); sl = q_addr.pop_front();
      e = q_exp.pop_front(); t = q_tag.pop_front();
      case (s)
        0: g = rd_a;
        1: g = rd_b;
        2: g = {27'd0, en_a};
        default: g = live_a[sl*32 +: 32];
      endcase
      n_vec++;
      if (g !== e) begin
        n_bad++;
        $display("FAIL %s: got %h expected %h", t, g, e);
      end
    end
  end

  task automatic wr(logic [6:0] a, logic [31:0] d, bit vs);
    wr_en = 1'b1; wr_addr = a; wr_data = d; vsync = vs;
    @(posedge clk); #1;
    wr_en = 1'b0; vsync = 1'b0;
  endtask

  task automatic vs();
    vsync = 1'b1;
    @(posedge clk); #1;
    vsync = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    chk(0, ad(0,0,0,0), 0, 32'h0, "R1 staging zero");
    chk(0, ad(0,1,4,3), 0, 32'h0, "R1 live zero");
    chk(0, ad(1,0,0,0), 0, 32'h0, "R1 control zero");
    chk(2, '0, 0, 32'h0, "R1 enables zero");

    wr(ad(0,0,1,2), 32'hAAAA0001, 0);
    chk(0, ad(0,0,1,2), 0, 32'hAAAA0001, "R2 staging readback");
    chk(0, ad(0,1,1,2), 0, 32'h0, "R2 live unchanged before vsync");
    vs();
    chk(0, ad(0,1,1,2), 0, 32'hAAAA0001, "R3 live after vsync");
    chk(1, ad(0,1,1,2), 0, 32'hAAAA0001, "R3 live after vsync global variant");
    chk(3, '0, 6, 32'hAAAA0001, "R3 live_cfg slot w1 f2");

    wr(ad(0,0,1,2), 32'hCCCC0002, 0);
    wr(ad(0,0,1,2), 32'hDDDD0003, 1);
    chk(0, ad(0,1,1,2), 0, 32'hCCCC0002, "R6 live takes pre-write value");
    chk(0, ad(0,0,1,2), 0, 32'hDDDD0003, "R6 staging takes written value");
    vs();
    chk(0, ad(0,1,1,2), 0, 32'hDDDD0003, "R6 next vsync moves new value");

    wr(ad(1,0,0,0), 32'h00000002, 0);
    chk(0, ad(1,0,0,0), 0, 32'h00000002, "R7 hold bit readback");
    chk(1, ad(1,0,0,0), 0, 32'h0, "R8 global drops hold bit 1");
    wr(ad(0,0,1,0), 32'h11110000, 0);
    wr(ad(0,0,2,0), 32'h22220000, 0);
    vs();
    chk(0, ad(0,1,1,0), 0, 32'h0, "R4 held window keeps live");
    chk(0, ad(0,1,2,0), 0, 32'h22220000, "R3 unheld window copies");
    chk(1, ad(0,1,1,0), 0, 32'h11110000, "R8 bit 1 has no effect in global");

    wr(ad(1,0,0,0), 32'h0, 0);
    chk(0, ad(0,1,1,0), 0, 32'h0, "R5 no copy before vsync");
    vs();
    chk(0, ad(0,1,1,0), 0, 32'h11110000, "R5 held value copied at next vsync");

    wr(ad(1,0,0,0), 32'h00000001, 0);
    wr(ad(0,0,3,3), 32'h33330000, 0);
    wr(ad(0,0,0,1), 32'h01010000, 0);
    vs();
    chk(1, ad(0,1,3,3), 0, 32'h0, "R8 global hold freezes window 3");
    chk(1, ad(0,1,0,1), 0, 32'h0, "R8 global hold freezes window 0");
    chk(0, ad(0,1,3,3), 0, 32'h33330000, "R4 per-window hold spares window 3");
    chk(0, ad(0,1,0,1), 0, 32'h0, "R4 per-window hold on window 0");
    chk(1, ad(1,0,0,0), 0, 32'h00000001, "R8 global hold readback");
    wr(ad(1,0,0,0), 32'h0, 0);
    vs();
    chk(1, ad(0,1,3,3), 0, 32'h33330000, "R5 global release copies");

    wr(ad(1,0,0,0), 32'h001F0004, 0);
    chk(2, '0, 0, 32'h1F, "R7 enables on port");
    chk(0, ad(1,0,0,0), 0, 32'h001F0004, "R7 control readback");
    chk(1, ad(1,0,0,0), 0, 32'h001F0000, "R8 control readback global");
    vs();
    chk(2, '0, 0, 32'h1F, "R7 enables unaffected by vsync");

    wr(ad(0,1,2,0), 32'hDEAD0000, 0);
    chk(0, ad(0,0,2,0), 0, 32'h22220000, "R9 live-address write ignored staging");
    chk(0, ad(0,1,2,0), 0, 32'h22220000, "R9 live-address write ignored live");
    wr(ad(0,0,6,0), 32'hBEEF0000, 0);
    chk(0, ad(0,0,6,0), 0, 32'h0, "R9 out-of-range read zero");
    chk(0, ad(0,0,0,0), 0, 32'h0, "R9 out-of-range write did not alias");

    @(posedge clk); #1;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule